// File: doc/BRIEF.md
# Interrupt Status and Clear Controller

This block collects five maskable interrupt sources of a small 8-bit computer's system gate array and drives one active-low IRQ line to the CPU. The sources are the vertical-sync point, a periodic timer tick, serial transmit empty, serial receive full and cassette high-tone detection. Each source has a sticky status bit. The CPU reads all of them, plus a summary IRQ bit, at the control address. A write to that same address loads the per-source enable mask. A write to the acknowledge address clears the chosen status bits.

The same acknowledge register has a second job. Bit 7 releases a freeze that a non-maskable interrupt request places on the video engine's RAM fetches. While that freeze is held, the `vid_fetch_en` output is low and the video logic must not start a memory fetch.

The vertical-sync source is tied to the video line counter. It becomes pending when the counter moves onto the first line below the displayed area. It falls again when the counter comes back to line 0.

Top module: `sysirq_ctrl`

## Requirements
- R1: After a synchronous reset, every status bit and every enable bit is 0, `irq_n` is 1 and `vid_fetch_en` is 1.
- R2: A read at the control address (default 0xFE00) returns the summary IRQ in bit 0 and the sources in bits 2..6 (2 vsync, 3 timer tick, 4 transmit empty, 5 receive full, 6 high tone). Bits 1 and 7 read as 0.
- R3: A write to the control address loads the enable mask from data bits 2..6, using the same bit positions as the status read. `irq_n` is 0 exactly when some status bit and its enable bit are both 1. The summary bit 0 equals the inverse of `irq_n`.
- R4: A one-cycle pulse on `rtc_tick`, `tx_empty`, `rx_full` or `tone_det` sets its status bit on the next clock edge. The bit then stays set until it is acknowledged.
- R5: A write to the acknowledge address (default 0xFE05) clears each status bit whose matching data bit (2..6) is 1. Status bits written with 0 keep their state.
- R6: When a source's set event and its acknowledge fall in the same cycle, the bit ends up set. An NMI request in the same cycle as a bit-7 acknowledge leaves the freeze in force.
- R7: The vsync bit is set on the cycle after `vid_line` first reaches VIS_LINES (default 256). It is cleared on the cycle after `vid_line` first reaches 0. Staying on either line does not set or clear it again.
- R8: A pulse on `nmi_req` drives `vid_fetch_en` low on the next edge. `vid_fetch_en` stays low until a write to the acknowledge address with bit 7 set. The status byte is not affected.
- R9: Writes to any other address change no enable and no status bit. Reads at any address other than the control address return 0.
- R10: A source whose enable bit is 0 still shows in the status read but does not pull `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data: the status byte at the control address, 0 elsewhere |
| vid_line | input | 9 | Current video line number |
| rtc_tick | input | 1 | Periodic timer event pulse |
| tx_empty | input | 1 | Serial transmit-empty event pulse |
| rx_full | input | 1 | Serial receive-full event pulse |
| tone_det | input | 1 | Cassette high-tone event pulse |
| nmi_req | input | 1 | Non-maskable interrupt request pulse |
| irq_n | output | 1 | Maskable interrupt to the CPU, active low |
| vid_fetch_en | output | 1 | Video RAM fetch permission, low while the NMI freeze is held |

## Verification
In this block, a source event and a CPU acknowledge of that same source can fall on the same clock edge. The bench provokes this for a pulse source (the tone event together with a bit-6 acknowledge), for vsync (the line counter entering line 256 together with a bit-2 acknowledge), and for the NMI freeze (a request together with a bit-7 acknowledge). In each case it reads the status byte or `vid_fetch_en` one cycle later and expects the set to have won. Control cases then show that the same acknowledge without the event does clear the bit.

// File: rtl/sysirq_pkg.sv
package sysirq_pkg;

    localparam int DATA_W      = 8;
    localparam int NUM_SRC     = 5;
    localparam int SRC_LSB     = 2;
    localparam int SUMMARY_BIT = 0;
    localparam int FREEZE_BIT  = 7;

    typedef enum logic [2:0] {
        SRC_VSYNC = 3'd0,
        SRC_TICK  = 3'd1,
        SRC_TXE   = 3'd2,
        SRC_RXF   = 3'd3,
        SRC_TONE  = 3'd4
    } src_idx_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic ctrl_sel;
        logic ctrl_wr;
        logic ack_wr;
    } bus_strobe_t;

    function automatic src_vec_t src_field(input logic [DATA_W-1:0] d);
        return d[SRC_LSB +: NUM_SRC];
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input src_vec_t s, input logic summary);
        logic [DATA_W-1:0] r;
        r = '0;
        r[SRC_LSB +: NUM_SRC] = s;
        r[SUMMARY_BIT] = summary;
        return r;
    endfunction

endpackage

// File: rtl/sysirq_bus_dec.sv
module sysirq_bus_dec
    import sysirq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] CTRL_ADDR = 16'hFE00,
    parameter logic [15:0] ACK_ADDR  = 16'hFE05
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output bus_strobe_t       strobe
);
    localparam logic [ADDR_W-1:0] CTRL_A = CTRL_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ACK_A  = ACK_ADDR[ADDR_W-1:0];

    always_comb begin
        strobe          = '0;
        strobe.ctrl_sel = (addr == CTRL_A);
        strobe.ctrl_wr  = wr && (addr == CTRL_A);
        strobe.ack_wr   = wr && (addr == ACK_A);
    end
endmodule

// File: rtl/sysirq_src_latch.sv
module sysirq_src_latch #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_i) | set_i;
    end

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R6
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> q[k]);
        // R5
        clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !q[k]);
    end
endmodule

// File: rtl/sysirq_vsync_det.sv
module sysirq_vsync_det #(
    parameter int LINE_W    = 9,
    parameter int VIS_LINES = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line,
    output logic              enter_end,
    output logic              enter_top
);
    localparam logic [LINE_W-1:0] END_LINE = LINE_W'(VIS_LINES);

    logic [LINE_W-1:0] prev_line;

    always_ff @(posedge clk) begin
        if (rst) prev_line <= '0;
        else     prev_line <= line;
    end

    assign enter_end = (line == END_LINE) && (prev_line != END_LINE);
    assign enter_top = (line == '0) && (prev_line != '0);
endmodule

// File: rtl/sysirq_nmi_hold.sv
module sysirq_nmi_hold (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic release_i,
    output logic fetch_en
);
    logic frozen;

    always_ff @(posedge clk) begin
        if (rst) frozen <= 1'b0;
        else     frozen <= req_i | (frozen & ~release_i);
    end

    assign fetch_en = ~frozen;

    // R8
    freeze_on_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_i |=> !fetch_en);
    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (release_i && !req_i) |=> fetch_en);
endmodule

// File: rtl/sysirq_ctrl.sv
module sysirq_ctrl
    import sysirq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          LINE_W    = 9,
    parameter int          VIS_LINES = 256,
    parameter logic [15:0] CTRL_ADDR = 16'hFE00,
    parameter logic [15:0] ACK_ADDR  = 16'hFE05
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [LINE_W-1:0] vid_line,
    input  logic              rtc_tick,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic              tone_det,
    input  logic              nmi_req,
    output logic              irq_n,
    output logic              vid_fetch_en
);
    bus_strobe_t strobe;
    src_vec_t    mask_q;
    src_vec_t    status_q;
    src_vec_t    set_vec;
    src_vec_t    clr_vec;
    logic        vs_enter_end;
    logic        vs_enter_top;
    logic        summary;

    sysirq_bus_dec #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .ACK_ADDR (ACK_ADDR)
    ) u_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .strobe(strobe)
    );

    sysirq_vsync_det #(
        .LINE_W   (LINE_W),
        .VIS_LINES(VIS_LINES)
    ) u_vs (
        .clk      (clk),
        .rst      (rst),
        .line     (vid_line),
        .enter_end(vs_enter_end),
        .enter_top(vs_enter_top)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[SRC_VSYNC] = vs_enter_end;
        set_vec[SRC_TICK]  = rtc_tick;
        set_vec[SRC_TXE]   = tx_empty;
        set_vec[SRC_RXF]   = rx_full;
        set_vec[SRC_TONE]  = tone_det;

        clr_vec = strobe.ack_wr ? src_field(bus_wdata) : '0;
        clr_vec[SRC_VSYNC] = clr_vec[SRC_VSYNC] | vs_enter_top;
    end

    sysirq_src_latch #(.N(NUM_SRC)) u_lat (
        .clk  (clk),
        .rst  (rst),
        .set_i(set_vec),
        .clr_i(clr_vec),
        .q    (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                 mask_q <= '0;
        else if (strobe.ctrl_wr) mask_q <= src_field(bus_wdata);
    end

    sysirq_nmi_hold u_nmi (
        .clk      (clk),
        .rst      (rst),
        .req_i    (nmi_req),
        .release_i(strobe.ack_wr && bus_wdata[FREEZE_BIT]),
        .fetch_en (vid_fetch_en)
    );

    assign summary   = |(status_q & mask_q);
    assign irq_n     = ~summary;
    assign bus_rdata = strobe.ctrl_sel ? pack_status(status_q, summary) : '0;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (status_q == '0 && mask_q == '0 && vid_fetch_en && irq_n));
    // R3
    mask_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe.ctrl_wr && src_field(bus_wdata) == '0) |=> irq_n);
    // R7
    vsync_raise_chk: assert property (@(posedge clk) disable iff (rst)
        vs_enter_end |=> status_q[SRC_VSYNC]);
    // R9
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !strobe.ctrl_wr) |=> $stable(mask_q));
endmodule

// File: tb/sysirq_ctrl_bench.sv
module sysirq_ctrl_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 14;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [8:0]  vid_line;
    logic        rtc_tick, tx_empty, rx_full, tone_det, nmi_req;
    logic        irq_n, vid_fetch_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysirq_ctrl u_sysirq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vid_line(vid_line),
        .rtc_tick(rtc_tick), .tx_empty(tx_empty), .rx_full(rx_full),
        .tone_det(tone_det), .nmi_req(nmi_req), .irq_n(irq_n),
        .vid_fetch_en(vid_fetch_en)
    );

    // vector: {wr, addr, wdata, events{tone,rxf,txe,tick}, expected status, expected irq_n}
    localparam logic [37:0] VEC [NVEC] = '{
        {1'b0, 16'hFE00, 8'h00, 4'b0001, 8'h08, 1'b1},
        {1'b1, 16'hFE00, 8'h08, 4'b0000, 8'h09, 1'b0},
        {1'b0, 16'hFE00, 8'h00, 4'b0010, 8'h19, 1'b0},
        {1'b1, 16'hFE05, 8'h08, 4'b0000, 8'h10, 1'b1},
        {1'b1, 16'hFE00, 8'h7C, 4'b0000, 8'h11, 1'b0},
        {1'b1, 16'hFE05, 8'h00, 4'b0000, 8'h11, 1'b0},
        {1'b0, 16'hFE00, 8'h00, 4'b1100, 8'h71, 1'b0},
        {1'b1, 16'hFE05, 8'h30, 4'b0000, 8'h41, 1'b0},
        {1'b1, 16'hFE05, 8'h40, 4'b1000, 8'h41, 1'b0},
        {1'b1, 16'hFE05, 8'h40, 4'b0000, 8'h00, 1'b1},
        {1'b1, 16'hFE01, 8'hFF, 4'b0000, 8'h00, 1'b1},
        {1'b1, 16'hFE04, 8'h08, 4'b0001, 8'h09, 1'b0},
        {1'b1, 16'hFE00, 8'h00, 4'b0000, 8'h08, 1'b1},
        {1'b1, 16'hFE05, 8'h08, 4'b0000, 8'h00, 1'b1}
    };
    localparam string VREQ [NVEC] = '{
        "R10", "R3", "R4", "R5", "R3", "R5", "R4",
        "R5", "R6", "R5", "R9", "R9", "R10", "R5"
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_addr = 16'hFE00; bus_wr = 1'b0; bus_wdata = 8'h00;
        rtc_tick = 1'b0; tx_empty = 1'b0; rx_full = 1'b0; tone_det = 1'b0;
        nmi_req = 1'b0;
    endtask

    // inputs were set after a falling edge; clock them in, then return to idle
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        #1;
    endtask

    task automatic expect_status(input string req, input logic [7:0] st, input logic irqn);
        check(bus_rdata == st, req, "status", bus_rdata, st);
        check(irq_n == irqn, req, "irq_n", {7'd0, irq_n}, {7'd0, irqn});
    endtask

    initial begin
        rst = 1'b1;
        vid_line = '0;
        idle_inputs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        expect_status("R1", 8'h00, 1'b1);
        check(vid_fetch_en == 1'b1, "R1", "fetch_en", {7'd0, vid_fetch_en}, 8'h01);

        // R2 R3 R4 R5 R6 R9 R10 vector walk
        for (int i = 0; i < NVEC; i++) begin
            bus_wr    = VEC[i][37];
            bus_addr  = VEC[i][36:21];
            bus_wdata = VEC[i][20:13];
            rtc_tick  = VEC[i][9];
            tx_empty  = VEC[i][10];
            rx_full   = VEC[i][11];
            tone_det  = VEC[i][12];
            step();
            expect_status(VREQ[i], VEC[i][8:1], VEC[i][0]);
        end

        // R7 vsync raise on entering line 256 (mask is 0)
        vid_line = 9'd255; step();
        vid_line = 9'd256; step();
        expect_status("R7", 8'h04, 1'b1);
        bus_wr = 1'b1; bus_wdata = 8'h04; step();
        expect_status("R3", 8'h05, 1'b0);
        // R7 staying on line 256 does not re-raise after ack
        bus_wr = 1'b1; bus_addr = 16'hFE05; bus_wdata = 8'h04; step();
        step();
        expect_status("R7", 8'h00, 1'b1);
        vid_line = 9'd257; step();
        vid_line = 9'd0;   step();
        vid_line = 9'd256; step();
        expect_status("R7", 8'h05, 1'b0);
        vid_line = 9'd0; step();
        expect_status("R7", 8'h00, 1'b1);
        // R6 vsync entry and ack together
        vid_line = 9'd255; step();
        vid_line = 9'd256; bus_wr = 1'b1; bus_addr = 16'hFE05; bus_wdata = 8'h04; step();
        expect_status("R6", 8'h05, 1'b0);
        vid_line = 9'd0; step();
        expect_status("R7", 8'h00, 1'b1);

        // R8 NMI freeze
        nmi_req = 1'b1; step();
        check(vid_fetch_en == 1'b0, "R8", "fetch_en", {7'd0, vid_fetch_en}, 8'h00);
        expect_status("R8", 8'h00, 1'b1);
        step();
        check(vid_fetch_en == 1'b0, "R8", "fetch_en held", {7'd0, vid_fetch_en}, 8'h00);
        bus_wr = 1'b1; bus_addr = 16'hFE05; bus_wdata = 8'h80; step();
        check(vid_fetch_en == 1'b1, "R8", "fetch_en released", {7'd0, vid_fetch_en}, 8'h01);
        nmi_req = 1'b1; step();
        bus_wr = 1'b1; bus_addr = 16'hFE05; bus_wdata = 8'h80; nmi_req = 1'b1; step();
        check(vid_fetch_en == 1'b0, "R6", "nmi vs release", {7'd0, vid_fetch_en}, 8'h00);
        bus_wr = 1'b1; bus_addr = 16'hFE05; bus_wdata = 8'h80; step();
        check(vid_fetch_en == 1'b1, "R8", "fetch_en released", {7'd0, vid_fetch_en}, 8'h01);

        // R9 read away from the control address returns 0
        rtc_tick = 1'b1; step();
        expect_status("R2", 8'h08, 1'b1);
        bus_addr = 16'hFE01; #1;
        check(bus_rdata == 8'h00, "R9", "stray read", bus_rdata, 8'h00);
        bus_addr = 16'hFE00;

        // R1 reset in mid-run clears status, mask and freeze
        bus_wr = 1'b1; bus_wdata = 8'h7C; step();
        nmi_req = 1'b1; step();
        expect_status("R3", 8'h09, 1'b0);
        rst = 1'b1; step();
        rst = 1'b0; #1;
        expect_status("R1", 8'h00, 1'b1);
        check(vid_fetch_en == 1'b1, "R1", "fetch_en", {7'd0, vid_fetch_en}, 8'h01);
        rtc_tick = 1'b1; step();
        expect_status("R1", 8'h08, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule